// File: doc/BRIEF.md
# Auto-reload timer core

This block is the counting core of a 16-bit up-counting time base. A separate clock divider produces a count strobe, and the core advances on that strobe. The core wraps at a programmable reload value and turns each wrap into an update event. It keeps a sticky update flag and raises an interrupt level and a DMA pulse. It also drives a selectable trigger output toward a converter or another timer. In the other direction it returns a clear pulse and an update pulse to the divider, so the divider can restart its own count and load a new ratio.

Software programs the core through a flat register port with a write strobe, a 3-bit write address, a data word and a separate read address with combinational read data. The reload value can be taken at once or held in a buffer until the next update. An update-block bit and an overflow-only bit choose when buffered values move and when the flag is set. A single-shot bit makes the core stop itself after one update.

Register map (word addresses): 0 control, 1 trigger select, 2 request enables, 3 status, 4 generate, 5 counter, 6 reload; address 7 reads zero.

Top module: `uptimer_core`

## Requirements
- R1: While counting is enabled and the active reload is non-zero, every cycle with `cnt_tick` high adds one to the counter (address 5). The strobe that finds the counter at or above the active reload returns it to 0 and counts as an overflow.
- R2: With control bit 4 (buffered) clear, a write to the reload register (address 6) changes the active reload at once. With it set, the write changes only the buffer (what address 6 reads back), and the buffer is copied to the active reload on the next update event.
- R3: Writing 1 to bit 0 of address 4 asks for a software update: the counter goes to 0, `psc_clear` pulses for one cycle and, when updates are allowed, `psc_reload` pulses too. Address 4 always reads 0. An overflow with updates allowed also pulses `psc_reload`, one cycle after the wrapping strobe.
- R4: With control bit 1 (update block) set, no update event occurs and the active reload keeps its value. A software request still clears the counter and pulses `psc_clear`.
- R5: With control bit 2 (overflow only) set, a software update still reloads the active values, but only an overflow update sets the flag.
- R6: With control bit 3 (single shot) set, the update event clears control bit 0 (run) and the counter stops advancing at once.
- R7: The internal count enable rises one cycle after control bit 0 is written to 1 and falls in the same cycle that bit 0 clears.
- R8: While the active reload is 0 the counter holds its value and no overflow occurs.
- R9: `trig_out` follows trigger select (address 2:0 of register 1): 000 gives a one-cycle pulse one cycle after a software request, 001 gives the internal count enable level, 010 gives a one-cycle pulse one cycle after each update event, and 011 to 111 hold it low.
- R10: After reset the reload reads 0xFFFF, and the counter, control, trigger select, enables and flag read 0, with all outputs low.
- R11: The update flag (status bit 0) is set by every update that R5 allows. It is cleared only by writing 0 to status bit 0, and writing 1 there has no effect. A set in the same cycle as a clear wins. `irq` is the flag ANDed with enable bit 0 of address 2.
- R12: With enable bit 1 of address 2 set, `dma_req` pulses for one cycle, one cycle after each update that sets the flag.
- R13: A write to the counter register takes priority over counting in the same cycle, and counting resumes from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count strobe from the clock divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| psc_clear | output | 1 | Pulse telling the divider to restart its count |
| psc_reload | output | 1 | Update pulse telling the divider to load its ratio |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request pulse |
| trig_out | output | 1 | Selectable trigger output |

## Verification
An overflow can set the update flag in the same cycle that software writes 0 to clear it. The bench provokes this by parking the counter at the reload value with the strobe low. It then raises the strobe in exactly the cycle that carries the status clear write. The outcome is judged at the ports: the counter must read 0, the flag must read 1 because the set wins, and `psc_reload` must pulse. The bench also checks that a counter write wins over a strobe arriving in the same cycle, and that counting resumes from the written value.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;
   localparam int unsigned REG_AW = 3;
   localparam int unsigned CTRL_W = 5;

   localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] A_TSEL   = 3'd1;
   localparam logic [REG_AW-1:0] A_REQEN  = 3'd2;
   localparam logic [REG_AW-1:0] A_STAT   = 3'd3;
   localparam logic [REG_AW-1:0] A_GEN    = 3'd4;
   localparam logic [REG_AW-1:0] A_CNT    = 3'd5;
   localparam logic [REG_AW-1:0] A_RELOAD = 3'd6;

   localparam logic [2:0] TS_GEN = 3'd0;
   localparam logic [2:0] TS_EN  = 3'd1;
   localparam logic [2:0] TS_UPD = 3'd2;

   // control word, bit 4 down to bit 0
   typedef struct packed {
      logic buffered;
      logic single;
      logic ovf_only;
      logic no_upd;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/uptimer_ctrl.sv
module uptimer_ctrl
   import uptimer_pkg::*;
#(
   parameter bit HAS_DMA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CTRL_W-1:0] wr_lo,
   input  logic              ovf,
   output ctrl_t             ctrl,
   output logic [2:0]        tsel,
   output logic              irq_en,
   output logic              dma_en,
   output logic              cnt_en,
   output logic              sw_gen,
   output logic              upd_evt,
   output logic              flag,
   output logic              irq,
   output logic              dma_req
);
   logic run_d1;
   logic flag_set;
   logic flag_clr;

   assign sw_gen   = wr_en && (wr_addr == A_GEN) && wr_lo[0];
   assign upd_evt  = !ctrl.no_upd && (ovf || sw_gen);
   assign flag_set = upd_evt && (ovf || !ctrl.ovf_only);
   assign flag_clr = wr_en && (wr_addr == A_STAT) && !wr_lo[0];
   assign cnt_en   = ctrl.run && run_d1;
   assign irq      = flag && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         run_d1 <= 1'b0;
         tsel   <= TS_GEN;
         irq_en <= 1'b0;
         dma_en <= 1'b0;
         flag   <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == A_CTRL)) ctrl <= ctrl_t'(wr_lo);
         if (upd_evt && ctrl.single) ctrl.run <= 1'b0;
         run_d1 <= ctrl.run;
         if (wr_en && (wr_addr == A_TSEL)) tsel <= wr_lo[2:0];
         if (wr_en && (wr_addr == A_REQEN)) begin
            irq_en <= wr_lo[0];
            dma_en <= wr_lo[1];
         end
         if (flag_set)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   generate
      if (HAS_DMA) begin : g_dma
         logic dma_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dma_q <= 1'b0;
            else        dma_q <= flag_set && dma_en;
         end
         assign dma_req = dma_q;
      end else begin : g_no_dma
         assign dma_req = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/uptimer_count.sv
module uptimer_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             tick,
   input  logic             sw_gen,
   input  logic             upd_evt,
   input  logic             buffered,
   input  logic             cnt_wr,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] shadow,
   output logic             ovf
);
   logic adv;

   assign adv = cnt_en && tick && (shadow != '0) && !cnt_wr && !sw_gen;
   assign ovf = adv && (cnt >= shadow);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload <= '1;
         shadow  <= '1;
      end else begin
         if (reload_wr) preload <= wr_val;
         if (reload_wr && !buffered) shadow <= wr_val;
         else if (upd_evt)           shadow <= preload;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (sw_gen)  cnt <= '0;
      else if (cnt_wr)  cnt <= wr_val;
      else if (ovf)     cnt <= '0;
      else if (adv)     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uptimer_trig.sv
module uptimer_trig (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] tsel,
   input  logic       cnt_en,
   input  logic       sw_gen,
   input  logic       upd_evt,
   output logic       trig_out,
   output logic       upd_pulse,
   output logic       clr_pulse
);
   logic gen_q;
   logic upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         gen_q <= sw_gen;
         upd_q <= upd_evt;
      end
   end

   assign clr_pulse = gen_q;
   assign upd_pulse = upd_q;

   always_comb begin
      case (tsel)
         uptimer_pkg::TS_GEN: trig_out = gen_q;
         uptimer_pkg::TS_EN:  trig_out = cnt_en;
         uptimer_pkg::TS_UPD: trig_out = upd_q;
         default:             trig_out = 1'b0;
      endcase
   end
endmodule

// File: rtl/uptimer_core.sv
module uptimer_core
   import uptimer_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DATA_W  = 16,
   parameter bit          HAS_DMA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              psc_clear,
   output logic              psc_reload,
   output logic              irq,
   output logic              dma_req,
   output logic              trig_out
);
   generate
      if (CNT_W < 2 || DATA_W < CNT_W || DATA_W < CTRL_W) begin : g_bad_cfg
         $error("uptimer_core: CNT_W must be >= 2 and DATA_W >= CNT_W and >= CTRL_W");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [2:0]       tsel_q;
   logic             irq_en;
   logic             dma_en;
   logic             cnt_en;
   logic             sw_gen;
   logic             upd_evt;
   logic             flag_q;
   logic             ovf;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] preload_q;
   logic [CNT_W-1:0] shadow_q;

   uptimer_ctrl #(.HAS_DMA(HAS_DMA)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_lo   (wr_data[CTRL_W-1:0]),
      .ovf     (ovf),
      .ctrl    (ctrl_q),
      .tsel    (tsel_q),
      .irq_en  (irq_en),
      .dma_en  (dma_en),
      .cnt_en  (cnt_en),
      .sw_gen  (sw_gen),
      .upd_evt (upd_evt),
      .flag    (flag_q),
      .irq     (irq),
      .dma_req (dma_req)
   );

   uptimer_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .tick      (cnt_tick),
      .sw_gen    (sw_gen),
      .upd_evt   (upd_evt),
      .buffered  (ctrl_q.buffered),
      .cnt_wr    (wr_en && (wr_addr == A_CNT)),
      .reload_wr (wr_en && (wr_addr == A_RELOAD)),
      .wr_val    (wr_data[CNT_W-1:0]),
      .cnt       (cnt_q),
      .preload   (preload_q),
      .shadow    (shadow_q),
      .ovf       (ovf)
   );

   uptimer_trig u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .tsel      (tsel_q),
      .cnt_en    (cnt_en),
      .sw_gen    (sw_gen),
      .upd_evt   (upd_evt),
      .trig_out  (trig_out),
      .upd_pulse (psc_reload),
      .clr_pulse (psc_clear)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:   rd_data[CTRL_W-1:0] = ctrl_q;
         A_TSEL:   rd_data[2:0]        = tsel_q;
         A_REQEN:  rd_data[1:0]        = {dma_en, irq_en};
         A_STAT:   rd_data[0]          = flag_q;
         A_CNT:    rd_data[CNT_W-1:0]  = cnt_q;
         A_RELOAD: rd_data[CNT_W-1:0]  = preload_q;
         default:  rd_data             = '0;
      endcase
   end
endmodule

// File: rtl/uptimer_core_chk.sv
module uptimer_core_chk
   import uptimer_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic              wr_bit0,
   input logic              run,
   input logic              no_upd,
   input logic              single,
   input logic [2:0]        tsel,
   input logic              flag,
   input logic              dma_req,
   input logic              trig_out,
   input logic              upd_pulse,
   input logic              cnt_en,
   input logic [CNT_W-1:0]  shadow,
   input logic [CNT_W-1:0]  cnt
);
   AST_NO_UPD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      no_upd |=> !upd_pulse); // R4

   AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_pulse && $past(single)) |-> !run); // R6

   AST_EN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_en) |-> $past(run)); // R7

   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow == '0 && !wr_en) |=> $stable(cnt)); // R8

   AST_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel > 3'd2) |-> !trig_out); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr_en && wr_addr == A_STAT && !wr_bit0)) |=> flag); // R11

   AST_DMA_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> flag); // R12
endmodule

bind uptimer_core uptimer_core_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_bit0   (wr_data[0]),
   .run       (ctrl_q.run),
   .no_upd    (ctrl_q.no_upd),
   .single    (ctrl_q.single),
   .tsel      (tsel_q),
   .flag      (flag_q),
   .dma_req   (dma_req),
   .trig_out  (trig_out),
   .upd_pulse (psc_reload),
   .cnt_en    (cnt_en),
   .shadow    (shadow_q),
   .cnt       (cnt_q)
);

// File: tb/uptimer_core_tb.sv
module uptimer_core_tb;
   localparam logic [2:0] AC = 3'd0, AT = 3'd1, AE = 3'd2, AS = 3'd3,
                          AG = 3'd4, AN = 3'd5, AR = 3'd6;

   typedef struct packed {
      logic [15:0] rl;
      logic [7:0]  n;
      logic [15:0] cnt;
      logic        flg;
   } vec_t;

   localparam vec_t VEC [0:6] = '{
      '{16'd5,     8'd3,  16'd3,  1'b0},
      '{16'd5,     8'd6,  16'd0,  1'b1},
      '{16'd5,     8'd8,  16'd2,  1'b1},
      '{16'd1,     8'd5,  16'd1,  1'b1},
      '{16'd0,     8'd5,  16'd0,  1'b0},
      '{16'hFFFF,  8'd10, 16'd10, 1'b0},
      '{16'd2,     8'd3,  16'd0,  1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        psc_clear, psc_reload, irq, dma_req, trig_out;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;
   logic seen_upd, seen_clr, seen_dma, seen_trig, trig_seen;
   logic [15:0] v;

   always #5 clk = ~clk;

   uptimer_core u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .psc_clear(psc_clear), .psc_reload(psc_reload),
      .irq(irq), .dma_req(dma_req), .trig_out(trig_out)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      seen_upd = psc_reload; seen_clr = psc_clear;
      seen_dma = dma_req;    seen_trig = trig_out;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] val);
      rd_addr = a;
      #1;
      val = rd_data;
   endtask

   task automatic start(input logic [15:0] c);
      wr(AC, c);
      @(negedge clk);
   endtask

   task automatic run_ticks(input int n);
      trig_seen = 1'b0;
      cnt_tick = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         trig_seen = trig_seen | trig_out;
      end
      cnt_tick = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog (all requirements): got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      rd(AN, v); chk("R10 counter", v, 16'h0000);
      rd(AR, v); chk("R10 reload", v, 16'hFFFF);
      rd(AC, v); chk("R10 control", v, 16'h0000);
      rd(AS, v); chk("R10 flag", v, 16'h0000);
      chk("R10 outputs", {11'd0, irq, dma_req, trig_out, psc_clear, psc_reload}, 16'h0000);

      // R7 enable lag, seen on trigger select 001 (R9)
      wr(AT, 16'd1);
      wr(AC, 16'h0001);
      chk("R7 enable not yet", {15'd0, trig_out}, 16'd0);
      @(negedge clk);
      chk("R7 R9 enable level", {15'd0, trig_out}, 16'd1);
      wr(AC, 16'h0000);
      chk("R7 enable falls at once", {15'd0, trig_out}, 16'd0);

      // R1 / R8 vector table, reload unbuffered
      for (int k = 0; k < 7; k++) begin
         wr(AC, 16'h0000);
         wr(AR, VEC[k].rl);
         wr(AN, 16'h0000);
         wr(AS, 16'h0000);
         start(16'h0001);
         run_ticks(int'(VEC[k].n));
         rd(AN, v);
         chk(VEC[k].rl == 0 ? "R8 zero reload holds" : "R1 count value", v, VEC[k].cnt);
         rd(AS, v);
         chk(VEC[k].rl == 0 ? "R8 no overflow" : "R1 overflow flag", v, {15'd0, VEC[k].flg});
      end
      wr(AC, 16'h0000);

      // R13 counter write beats a strobe
      wr(AR, 16'h0100);
      wr(AN, 16'h0000);
      start(16'h0001);
      cnt_tick = 1'b1;
      wr(AN, 16'h0050);
      rd(AN, v); chk("R13 write wins", v, 16'h0050);
      @(negedge clk);
      rd(AN, v); chk("R13 resumes", v, 16'h0051);
      cnt_tick = 1'b0;
      wr(AC, 16'h0000);

      // R2 buffered reload, R3 software update
      wr(AC, 16'h0010);
      wr(AR, 16'd2);
      rd(AR, v); chk("R2 buffer readback", v, 16'd2);
      wr(AN, 16'h0000);
      start(16'h0011);
      run_ticks(4);
      rd(AN, v); chk("R2 old active reload kept", v, 16'd4);
      wr(AC, 16'h0010);
      wr(AS, 16'h0000);
      wr(AG, 16'h0001);
      chk("R3 update and clear pulses", {14'd0, seen_upd, seen_clr}, 16'd3);
      rd(AN, v); chk("R3 counter cleared", v, 16'd0);
      rd(AS, v); chk("R3 flag set", v, 16'd1);
      rd(AG, v); chk("R3 generate reads zero", v, 16'd0);
      start(16'h0011);
      run_ticks(3);
      rd(AN, v); chk("R2 new reload after update", v, 16'd0);
      wr(AC, 16'h0010);

      // R4 update block
      wr(AR, 16'd9);
      wr(AN, 16'd7);
      wr(AS, 16'h0000);
      wr(AC, 16'h0012);
      wr(AG, 16'h0001);
      chk("R4 clear only", {14'd0, seen_upd, seen_clr}, 16'd1);
      rd(AN, v); chk("R4 counter cleared", v, 16'd0);
      rd(AS, v); chk("R4 flag untouched", v, 16'd0);
      start(16'h0013);
      run_ticks(3);
      rd(AN, v); chk("R4 active reload kept", v, 16'd0);
      rd(AS, v); chk("R4 overflow blocked", v, 16'd0);
      wr(AC, 16'h0010);

      // R5 overflow-only flag source
      wr(AC, 16'h0014);
      wr(AS, 16'h0000);
      wr(AG, 16'h0001);
      chk("R5 update pulse", {15'd0, seen_upd}, 16'd1);
      rd(AS, v); chk("R5 flag not set by software", v, 16'd0);
      start(16'h0015);
      run_ticks(3);
      rd(AN, v); chk("R5 shadow reloaded", v, 16'd3);
      run_ticks(7);
      rd(AN, v); chk("R5 wrap", v, 16'd0);
      rd(AS, v); chk("R5 flag by overflow", v, 16'd1);
      wr(AC, 16'h0014);

      // R11 flag and interrupt, R12 DMA pulse
      wr(AE, 16'h0003);
      chk("R11 irq follows flag", {15'd0, irq}, 16'd1);
      wr(AS, 16'h0001);
      rd(AS, v); chk("R11 write one no effect", v, 16'd1);
      wr(AS, 16'h0000);
      chk("R11 irq cleared", {15'd0, irq}, 16'd0);
      wr(AC, 16'h0010);
      wr(AG, 16'h0001);
      chk("R12 dma pulse", {15'd0, seen_dma}, 16'd1);
      @(negedge clk);
      chk("R12 dma one cycle", {15'd0, dma_req}, 16'd0);
      wr(AC, 16'h0014);
      wr(AS, 16'h0000);
      wr(AG, 16'h0001);
      chk("R12 no dma without flag", {15'd0, seen_dma}, 16'd0);

      // R11 same cycle: overflow set against software clear
      wr(AC, 16'h0000);
      wr(AR, 16'd3);
      wr(AN, 16'd3);
      wr(AS, 16'h0000);
      start(16'h0001);
      @(negedge clk);
      cnt_tick = 1'b1; wr_en = 1'b1; wr_addr = AS; wr_data = 16'h0000;
      @(negedge clk);
      cnt_tick = 1'b0; wr_en = 1'b0;
      chk("R3 overflow update pulse", {15'd0, psc_reload}, 16'd1);
      rd(AN, v); chk("R1 wrap at reload", v, 16'd0);
      rd(AS, v); chk("R11 set wins over clear", v, 16'd1);
      wr(AC, 16'h0000);

      // R6 single shot, R9 trigger select
      wr(AN, 16'h0000);
      wr(AS, 16'h0000);
      wr(AT, 16'd2);
      start(16'h0009);
      run_ticks(10);
      chk("R9 update trigger", {15'd0, trig_seen}, 16'd1);
      rd(AN, v); chk("R6 stopped at zero", v, 16'd0);
      rd(AC, v); chk("R6 run cleared", v, 16'h0008);
      wr(AT, 16'd5);
      wr(AG, 16'h0001);
      chk("R9 unused code low", {15'd0, seen_trig}, 16'd0);
      wr(AT, 16'd0);
      wr(AG, 16'h0001);
      chk("R9 generate trigger", {15'd0, seen_trig}, 16'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule